// File: doc/BRIEF.md
# Two-Wire Compact JTAG Bit Sequencer

This block turns a stream of 4-wire JTAG bits (one TDI value and one TMS value per bit) into traffic on a 2-wire compact link. The link has a clock wire, TCKC, and one shared bidirectional data wire, TMSC. Each accepted JTAG bit becomes three clock periods on TCKC. In the first period the block drives the inverted TDI value onto TMSC. In the second it drives TMS. In the third it releases TMSC to high impedance so the target can drive the line, and it samples the returned bit as TDO. The recovered TDO leaves the block on an output stream.

The link is not ready for bits until it has been put into 2-wire mode. A command pulse makes the block hold TCKC high while it toggles TMSC a requested number of times (an escape sequence), and then lower TCKC. While this runs, the mode-select output stays at 0. It goes to 1 only when the sequence has finished with the enable flag set. Dropping the enable flag clears it at once.

Bits come in on a valid/ready stream. A bit is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays low while a bit or an escape is in progress, while mode-select is 0, while an escape request is present, and while an earlier TDO result has not yet been taken. TDO goes out on a valid/ready stream. `out_valid` and `out_tdo` hold until `out_ready` is seen, and this holds off the next input bit.

Top module: `twl_bit_sequencer`

## Requirements
- R1: After reset, `tckc` is 0, `tmsc_oe` is 0, `link_sel` is 0, `in_ready` is 0 and `out_valid` is 0.
- R2: `in_ready` is 1 only when `link_sel` is 1, no bit or escape is in progress, `esc_go` is 0 and no TDO result is pending. A bit offered while `in_ready` is 0 produces no TCKC activity.
- R3: Each accepted bit produces exactly three rising edges on `tckc`. Each half period lasts HALF_CYC clocks, and `out_valid` rises 6*HALF_CYC clocks after the accepting edge.
- R4: At the first TCKC rising edge of a bit, `tmsc_oe` is 1 and `tmsc_o` equals the inverse of the accepted TDI.
- R5: At the second TCKC rising edge of a bit, `tmsc_oe` is 1 and `tmsc_o` equals the accepted TMS.
- R6: During the whole third phase `tmsc_oe` is 0. `out_tdo` equals the value of `tmsc_i` at the third TCKC rising edge.
- R7: Once set, `out_valid` and `out_tdo` hold unchanged until a clock edge where `out_ready` is 1.
- R8: An escape started by `esc_go` drives `tmsc_oe` to 1 and sets TMSC to 1 with TCKC low. It then raises TCKC, toggles `tmsc_o` exactly `esc_len` times while TCKC stays high, and lowers TCKC. Bits and escapes never overlap.
- R9: `link_sel` is 0 while an escape runs and becomes 1 when an escape finishes with `en` at 1. It is cleared on any edge where `en` is 0.
- R10: While TCKC is high during a bit, `tmsc_o` and `tmsc_oe` do not change. Data changes only on the falling half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | 2-wire mode enable |
| esc_go | input | 1 | Start an escape sequence (taken when idle) |
| esc_len | input | ESC_W | Number of TMSC toggles in the escape |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Input bit accepted this edge if valid |
| in_tdi | input | 1 | TDI value of the bit |
| in_tms | input | 1 | TMS value of the bit |
| out_valid | output | 1 | TDO result valid |
| out_ready | input | 1 | Consumer takes the TDO result |
| out_tdo | output | 1 | Recovered TDO |
| tckc | output | 1 | Link clock |
| tmsc_o | output | 1 | Data line drive value |
| tmsc_oe | output | 1 | Data line drive enable |
| tmsc_i | input | 1 | Data line sampled value |
| link_sel | output | 1 | Mode select into 2-wire operation |

## Verification
On every cycle the assertions check that ready never appears without mode-select, that a bit and an escape never overlap, that mode-select stays low during an escape, and that TMSC holds still across a high TCKC half. They also check that the TDO result is held under back-pressure and that escape toggles happen only with TCKC high. Only the bench scenarios can show the phase order and values, the exact clock count per bit, and which phase TDO is sampled in (the bench target drives the opposite value outside the turnaround phase). The same holds for the toggle count of each escape length.

// File: rtl/twl_pkg.sv
package twl_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_TDI, PH_TMS, PH_TDO} bit_phase_t;
  typedef enum logic [1:0] {ES_IDLE, ES_PRE, ES_HOLD, ES_POST} esc_state_t;
endpackage

// File: rtl/twl_half_timer.sv
module twl_half_timer #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= RELOAD;
    else if (!run || tick)    cnt <= RELOAD;
    else                      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/twl_bit_fsm.sv
module twl_bit_fsm
  import twl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tdi,
  input  logic tms,
  input  logic tick,
  input  logic line_in,
  input  logic res_ready,
  output logic busy,
  output logic res_valid,
  output logic res_tdo,
  output logic clk_o,
  output logic line_o,
  output logic line_oe
);
  bit_phase_t ph;
  logic hi, tms_q, samp;

  assign busy = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; hi <= 1'b0; tms_q <= 1'b0; samp <= 1'b0;
      clk_o <= 1'b0; line_o <= 1'b0; line_oe <= 1'b0;
      res_valid <= 1'b0; res_tdo <= 1'b0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (start) begin
        ph <= PH_TDI; hi <= 1'b0; clk_o <= 1'b0;
        line_o <= ~tdi; line_oe <= 1'b1; tms_q <= tms;
      end else if (busy && tick) begin
        if (!hi) begin
          hi <= 1'b1; clk_o <= 1'b1;
          if (ph == PH_TDO) samp <= line_in;
        end else begin
          hi <= 1'b0; clk_o <= 1'b0;
          unique case (ph)
            PH_TDI: begin ph <= PH_TMS; line_o <= tms_q; end
            PH_TMS: begin ph <= PH_TDO; line_oe <= 1'b0; end
            PH_TDO: begin ph <= PH_IDLE; res_valid <= 1'b1; res_tdo <= samp; end
            default: ph <= PH_IDLE;
          endcase
        end
      end
    end
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_tdo))); // R7
  AST_RELEASED_IN_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clk_o && $past(line_oe) && !line_oe) |-> 1'b0); // R6
endmodule

// File: rtl/twl_escape_gen.sv
module twl_escape_gen
  import twl_pkg::*;
#(
  parameter int ESC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ESC_W-1:0] len,
  input  logic             tick,
  output logic             busy,
  output logic             done,
  output logic             clk_o,
  output logic             line_o,
  output logic             line_oe
);
  esc_state_t st;
  logic [ESC_W-1:0] left;

  assign busy = (st != ES_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ES_IDLE; left <= '0; done <= 1'b0;
      clk_o <= 1'b0; line_o <= 1'b0; line_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st <= ES_PRE; clk_o <= 1'b0; line_o <= 1'b1; line_oe <= 1'b1; left <= len;
      end else if (tick) begin
        unique case (st)
          ES_PRE:  begin st <= ES_HOLD; clk_o <= 1'b1; end
          ES_HOLD: begin
            if (left != '0) begin
              line_o <= ~line_o; left <= left - 1'b1;
            end else begin
              st <= ES_POST; clk_o <= 1'b0;
            end
          end
          ES_POST: begin st <= ES_IDLE; line_oe <= 1'b0; done <= 1'b1; end
          default: st <= ES_IDLE;
        endcase
      end
    end
  end

  AST_TOGGLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(line_o)) |-> clk_o); // R8
endmodule

// File: rtl/twl_bit_sequencer.sv
module twl_bit_sequencer #(
  parameter int HALF_CYC = 2,
  parameter int ESC_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             esc_go,
  input  logic [ESC_W-1:0] esc_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_tdi,
  input  logic             in_tms,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_tdo,
  output logic             tckc,
  output logic             tmsc_o,
  output logic             tmsc_oe,
  input  logic             tmsc_i,
  output logic             link_sel
);
  logic tick, bit_busy, esc_busy, esc_done, esc_start, bit_start;
  logic b_clk, b_o, b_oe, e_clk, e_o, e_oe;

  assign esc_start = esc_go && !bit_busy && !esc_busy;
  assign in_ready  = link_sel && !bit_busy && !esc_busy && !esc_go && !out_valid;
  assign bit_start = in_valid && in_ready;

  twl_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(bit_busy || esc_busy), .tick(tick));

  twl_bit_fsm u_bit (
    .clk(clk), .rst_n(rst_n), .start(bit_start), .tdi(in_tdi), .tms(in_tms),
    .tick(tick), .line_in(tmsc_i), .res_ready(out_ready), .busy(bit_busy),
    .res_valid(out_valid), .res_tdo(out_tdo), .clk_o(b_clk), .line_o(b_o),
    .line_oe(b_oe));

  twl_escape_gen #(.ESC_W(ESC_W)) u_esc (
    .clk(clk), .rst_n(rst_n), .start(esc_start), .len(esc_len), .tick(tick),
    .busy(esc_busy), .done(esc_done), .clk_o(e_clk), .line_o(e_o), .line_oe(e_oe));

  assign tckc    = b_clk | e_clk;
  assign tmsc_oe = b_oe | e_oe;
  assign tmsc_o  = esc_busy ? e_o : b_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     link_sel <= 1'b0;
    else if (!en || esc_start)      link_sel <= 1'b0;
    else if (esc_done)              link_sel <= 1'b1;
  end

  AST_READY_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> link_sel); // R2
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_busy && esc_busy)); // R8
  AST_SEL_LOW_IN_ESC: assert property (@(posedge clk) disable iff (!rst_n)
    esc_busy |-> !link_sel); // R9
  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tckc && $past(tckc) && bit_busy && $past(bit_busy)) |-> ($stable(tmsc_o) && $stable(tmsc_oe))); // R10
endmodule

// File: tb/test_twl_bit_sequencer.sv
module test_twl_bit_sequencer;
  localparam int HALF_CYC = 2;
  localparam int ESC_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, esc_go = 1'b0;
  logic [ESC_W-1:0] esc_len = '0;
  logic in_valid = 1'b0, in_tdi = 1'b0, in_tms = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_tdo, tckc, tmsc_o, tmsc_oe, tmsc_i, link_sel;
  logic want = 1'b0;
  int vec = 0, bad = 0;

  always #2 clk = ~clk;

  // target model: drives the wanted bit only while the probe releases the line
  assign tmsc_i = tmsc_oe ? ~want : want;

  twl_bit_sequencer #(.HALF_CYC(HALF_CYC), .ESC_W(ESC_W)) i_twl_bit_sequencer (
    .clk(clk), .rst_n(rst_n), .en(en), .esc_go(esc_go), .esc_len(esc_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_tdi(in_tdi), .in_tms(in_tms),
    .out_valid(out_valid), .out_ready(out_ready), .out_tdo(out_tdo),
    .tckc(tckc), .tmsc_o(tmsc_o), .tmsc_oe(tmsc_oe), .tmsc_i(tmsc_i),
    .link_sel(link_sel));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_escape(input int len, input bit en_v);
    int tog = 0, cyc = 0;
    logic pc, po;
    @(negedge clk);
    esc_len = ESC_W'(len); esc_go = 1'b1;
    @(negedge clk);
    esc_go = 1'b0;
    chk(tmsc_oe == 1'b1 && tmsc_o == 1'b1 && tckc == 1'b0, "R8 start", tmsc_o, 1);
    pc = tckc; po = tmsc_o;
    while (tmsc_oe && cyc < 1000) begin
      @(negedge clk); cyc++;
      if (tmsc_oe && link_sel) chk(0, "R9 sel during escape", 1, 0);
      if (pc && tckc && (tmsc_o != po)) tog++;
      pc = tckc; po = tmsc_o;
    end
    chk(tog == len, "R8 toggle count", tog, len);
    @(negedge clk);
    chk(link_sel == en_v, "R9 sel after escape", link_sel, en_v);
  endtask

  task automatic send_bit(input bit t_di, input bit t_ms, input bit w, input bit hold_out);
    int cyc = 0, nr = 0;
    logic ro[3], roe[3];
    logic pc, po, poe;
    bit ph2_ok = 1, stab_ok = 1;
    while (!in_ready) @(negedge clk);
    want = w; in_tdi = t_di; in_tms = t_ms; in_valid = 1'b1; out_ready = !hold_out;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    pc = tckc; po = tmsc_o; poe = tmsc_oe;
    while (!out_valid && cyc < 1000) begin
      if (tckc && !pc && nr < 3) begin ro[nr] = tmsc_o; roe[nr] = tmsc_oe; nr++; end
      else if (tckc && !pc) nr++;
      if (nr == 3 && tmsc_oe) ph2_ok = 0;
      if (tckc && pc && (tmsc_o != po || tmsc_oe != poe)) stab_ok = 0;
      pc = tckc; po = tmsc_o; poe = tmsc_oe;
      cyc++;
      @(negedge clk);
    end
    chk(nr == 3, "R3 rise count", nr, 3);
    chk(cyc == 6 * HALF_CYC, "R3 bit length", cyc, 6 * HALF_CYC);
    if (nr == 3) begin
      chk(roe[0] && ro[0] == ~t_di, "R4 nTDI phase", ro[0], !t_di);
      chk(roe[1] && ro[1] == t_ms, "R5 TMS phase", ro[1], t_ms);
      chk(!roe[2], "R6 released at third rise", roe[2], 0);
    end
    chk(ph2_ok, "R6 released whole phase", 0, 1);
    chk(stab_ok, "R10 stable while high", 0, 1);
    chk(out_tdo == w, "R6 TDO value", out_tdo, w);
    if (hold_out) begin
      want = ~w;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk(out_valid && out_tdo == w, "R7 held", out_tdo, w);
        chk(!in_ready, "R2 ready under back-pressure", in_ready, 0);
      end
      out_ready = 1'b1;
      @(negedge clk);
      chk(!out_valid, "R7 released", out_valid, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!tckc && !tmsc_oe && !link_sel && !in_ready && !out_valid, "R1 reset state",
        {tckc, tmsc_oe, link_sel, in_ready, out_valid}, 0);
    rst_n = 1'b1;
    en = 1'b1;
    in_valid = 1'b1;
    begin
      bit quiet = 1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (in_ready || tckc) quiet = 0;
      end
      chk(quiet, "R2 no link before escape", !quiet, 0);
    end
    in_valid = 1'b0;
    for (int len = 0; len < 8; len++) run_escape(len, 1'b1);
    for (int v = 0; v < 8; v++) send_bit(v[0], v[1], v[2], 1'b0);
    send_bit(1'b1, 1'b0, 1'b1, 1'b1);
    send_bit(1'b0, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!link_sel && !in_ready, "R9 cleared by enable low", link_sel, 0);
    run_escape(3, 1'b0);
    en = 1'b1;
    run_escape(5, 1'b1);
    send_bit(1'b0, 1'b0, 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule